// File: doc/BRIEF.md
# Tower-field GF(2^2n) multiplier

This block multiplies two elements of a binary extension field. The field is built as a tower of degree-two extensions: GF(2^2) over GF(2), GF(2^4) over GF(2^2), GF(2^8) over GF(2^4), and so on up to the depth set by a parameter. At every level an element is held as a pair (X0, X1) that stands for X0 + X1·a. The generator a of that level satisfies a^2 = a + N, where N is a nonzero constant of the subfield below.

Each level computes its product from three subfield products, X0·Y0, X1·Y1 and (X0+X1)·(Y0+Y1). It adds one multiplication by the fixed constant N and combines the results with XOR. At the bottom level the three subfield products are single AND gates, so the whole datapath is AND and XOR gates with no lookup table. Several independent lanes can be placed side by side, so that many blocks are multiplied in the same cycle. A parameter selects a registered output or a purely combinational path. A typical user is a bit-sliced, table-free substitution-box datapath.

Top module: `gf_tower_mul`

## Requirements
- R1: The field word is 2^DEPTH bits wide. Its low half is X0 and its high half is X1, giving the element X0 + X1·a, and each half is encoded the same way one level down. The value 0 is all zeros and the value 1 has only bit 0 set. With the default constants, 8'h10·8'h10 = 8'h1C, 8'h04·8'h04 = 8'h06 and 8'h02·8'h02 = 8'h03.
- R2: At every level the product is Z0 = X0·Y0 ^ N·(X1·Y1) and Z1 = X0·Y1 ^ X1·Y0 ^ X1·Y1. This is computed as Z1 = (X0^X1)·(Y0^Y1) ^ X0·Y0. The GF(2^2) level uses N = 1.
- R3: The constant of each level above GF(2^2) is a parameter, packed in TOWER_N with the GF(2^4) constant in the low 2 bits and the GF(2^8) constant in the next 4 bits. The defaults are 2'b10 and 4'b1100, each with its top bit set, which makes x^2 + x + N irreducible. With these constants, any two nonzero operands give a nonzero product.
- R4: The product is commutative: swapping the two operands gives the same result.
- R5: If either operand is zero, the product is zero.
- R6: Multiplying by the value 1 returns the other operand unchanged.
- R7: Lane i uses bits [i·W +: W] of each operand and of the product. Lanes do not affect one another.
- R8: With REG_OUT = 1, the product of operands present at a rising clock edge appears on prod_o just after that edge and holds until the next edge. With REG_OUT = 0, the product follows the operands combinationally.
- R9: With REG_OUT = 1, a low rst_n at a rising edge clears every lane of prod_o to zero (synchronous, active low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| opa_i | input | LANES·2^DEPTH | First operand, one field word per lane |
| opb_i | input | LANES·2^DEPTH | Second operand, one field word per lane |
| prod_o | output | LANES·2^DEPTH | Product, one field word per lane |

## Verification
The bench builds the block with DEPTH = 3 (GF(2^8)), two lanes, a registered output and the default tower constants. With these values the full 2^16 space of operand pairs is small enough to cover exhaustively. Each pair is sent on lane 0 and its swapped copy on lane 1, so commutativity is compared in the same cycle as the match against a schoolbook reference model. Random independent lane pairs, the generator squares of each tower level, and the hold and reset behaviour of the output register complete the set.

// File: rtl/gf_tower_pkg.sv
// Package gf_tower_pkg
// Width helpers shared by the tower-field multiplier and its checker.
// A tower of depth K holds 2^K-bit field words. The per-level constants
// for levels 1..K are packed into one vector of 2^K - 1 bits, with the
// constant of level k (2^(k-1) bits wide) at offset 2^(k-1) - 1.
package gf_tower_pkg;

    // Bits in a field word of a tower of the given depth.
    function automatic int field_w(input int depth);
        return 1 << depth;
    endfunction

    // Bits in the packed constant vector for levels 1..depth.
    function automatic int nvec_w(input int depth);
        return (1 << depth) - 1;
    endfunction

endpackage

// File: rtl/gf_tower_mul_rec.sv
// Module gf_tower_mul_rec
// Recursive multiplier for a tower field of depth K. Operands are split into
// (X0, X1) halves over the subfield of depth K-1. Three subfield products and
// one product by the level constant are combined with XOR. At K == 1 the
// subfield is GF(2), so the products are single AND gates.
// Assumes: NS holds an irreducible constant per level (level 1 must be 1).
module gf_tower_mul_rec
    import gf_tower_pkg::*;
#(
    parameter int                    K  = 3,
    parameter logic [nvec_w(K)-1:0]  NS = '1
) (
    input  logic [field_w(K)-1:0] x_i,
    input  logic [field_w(K)-1:0] y_i,
    output logic [field_w(K)-1:0] z_o
);

    localparam int W = field_w(K);
    localparam int H = W / 2;

    generate
        if (K == 1) begin : g_base
            logic p_lo, p_hi, p_mid;

            // Three AND-gate products over GF(2).
            always_comb begin
                p_lo  = x_i[0] & y_i[0];
                p_hi  = x_i[1] & y_i[1];
                p_mid = (x_i[0] ^ x_i[1]) & (y_i[0] ^ y_i[1]);
            end

            // Recombine with a^2 = a + N, N taken from the constant vector.
            always_comb begin
                z_o[0] = p_lo ^ (NS[0] & p_hi);
                z_o[1] = p_mid ^ p_lo;
            end
        end else begin : g_split
            localparam logic [nvec_w(K-1)-1:0] NS_SUB = NS[nvec_w(K-1)-1:0];
            localparam logic [H-1:0]           N_LVL  = NS[nvec_w(K)-1:nvec_w(K-1)];

            logic [H-1:0] x0, x1, y0, y1;
            logic [H-1:0] xs, ys;
            logic [H-1:0] p_lo, p_hi, p_mid, p_hi_n;

            // Split operands into halves and form the Karatsuba sums.
            always_comb begin
                x0 = x_i[H-1:0];
                x1 = x_i[W-1:H];
                y0 = y_i[H-1:0];
                y1 = y_i[W-1:H];
                xs = x0 ^ x1;
                ys = y0 ^ y1;
            end

            gf_tower_mul_rec #(.K(K-1), .NS(NS_SUB)) u_mul_lo (
                .x_i(x0), .y_i(y0), .z_o(p_lo)
            );
            gf_tower_mul_rec #(.K(K-1), .NS(NS_SUB)) u_mul_hi (
                .x_i(x1), .y_i(y1), .z_o(p_hi)
            );
            gf_tower_mul_rec #(.K(K-1), .NS(NS_SUB)) u_mul_mid (
                .x_i(xs), .y_i(ys), .z_o(p_mid)
            );
            // Product by the fixed level constant; one operand is tied off.
            gf_tower_mul_rec #(.K(K-1), .NS(NS_SUB)) u_mul_const (
                .x_i(p_hi), .y_i(N_LVL), .z_o(p_hi_n)
            );

            // Recombine the halves of the product.
            always_comb begin
                z_o = {p_mid ^ p_lo, p_lo ^ p_hi_n};
            end
        end
    endgenerate

endmodule

// File: rtl/gf_out_stage.sv
// Module gf_out_stage
// Optional output register for the multiplier lanes. With REG = 1 it is a
// register with a synchronous active-low clear; with REG = 0 it is a wire.
// Assumes: clk and rst_n are used only when REG = 1.
module gf_out_stage #(
    parameter int TW  = 16,
    parameter bit REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] d_i,
    output logic [TW-1:0] q_o
);

    generate
        if (REG) begin : g_reg
            // Capture the products each cycle, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_o <= '0;
                else        q_o <= d_i;
            end
        end else begin : g_wire
            // Pass the products straight through.
            always_comb q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/gf_tower_mul.sv
// Module gf_tower_mul
// Multi-lane tower-field multiplier over GF(2^(2^DEPTH)). Each lane multiplies
// one pair of field words with an AND/XOR-only recursive datapath. All lanes
// share an optional output register.
// Assumes: TOWER_N holds the constants of levels 2..DEPTH (level k at
// offset 2^(k-1) - 2, width 2^(k-1)), each making x^2 + x + N irreducible.
module gf_tower_mul
    import gf_tower_pkg::*;
#(
    parameter int                       DEPTH   = 3,
    parameter int                       LANES   = 2,
    parameter bit                       REG_OUT = 1'b1,
    parameter logic [nvec_w(DEPTH)-2:0] TOWER_N = 6'b1100_10
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [LANES*field_w(DEPTH)-1:0]  opa_i,
    input  logic [LANES*field_w(DEPTH)-1:0]  opb_i,
    output logic [LANES*field_w(DEPTH)-1:0]  prod_o
);

    localparam int                       W  = field_w(DEPTH);
    localparam int                       TW = LANES * W;
    localparam logic [nvec_w(DEPTH)-1:0] NS = {TOWER_N, 1'b1};

    logic [TW-1:0] prod_c;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            gf_tower_mul_rec #(.K(DEPTH), .NS(NS)) u_mul (
                .x_i(opa_i[l*W +: W]),
                .y_i(opb_i[l*W +: W]),
                .z_o(prod_c[l*W +: W])
            );
        end
    endgenerate

    gf_out_stage #(.TW(TW), .REG(REG_OUT)) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (prod_c),
        .q_o  (prod_o)
    );

endmodule

// File: rtl/gf_tower_mul_chk.sv
// Module gf_tower_mul_chk
// Property checker for gf_tower_mul, attached by bind. It relates each lane's
// product to the operands it was computed from. Those operands are delayed
// one cycle when the output is registered and taken as they are otherwise.
module gf_tower_mul_chk
    import gf_tower_pkg::*;
#(
    parameter int DEPTH   = 3,
    parameter int LANES   = 2,
    parameter bit REG_OUT = 1'b1
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [LANES*field_w(DEPTH)-1:0]  opa_i,
    input logic [LANES*field_w(DEPTH)-1:0]  opb_i,
    input logic [LANES*field_w(DEPTH)-1:0]  prod_o
);

    localparam int            W   = field_w(DEPTH);
    localparam int            TW  = LANES * W;
    localparam logic [W-1:0]  ONE = W'(1);

    logic [TW-1:0] a_d, b_d;
    logic          hist_ok;
    logic          rst_seen;

    generate
        if (REG_OUT) begin : g_hist
            // Track the operands behind the current product and the reset history.
            always_ff @(posedge clk) begin
                a_d      <= opa_i;
                b_d      <= opb_i;
                rst_seen <= !rst_n;
                if (!rst_n) hist_ok <= 1'b0;
                else        hist_ok <= 1'b1;
            end
        end else begin : g_now
            // Combinational variant: the product belongs to the present operands.
            always_comb begin
                a_d      = opa_i;
                b_d      = opb_i;
                rst_seen = 1'b0;
                hist_ok  = 1'b1;
            end
        end
    endgenerate

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_seen |-> prod_o == '0); // R9

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
            AST_ZERO_ANNIHILATES: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && (a_d[l*W +: W] == '0 || b_d[l*W +: W] == '0))
                |-> prod_o[l*W +: W] == '0); // R5

            AST_ONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && a_d[l*W +: W] == ONE)
                |-> prod_o[l*W +: W] == b_d[l*W +: W]); // R6

            AST_NO_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && a_d[l*W +: W] != '0 && b_d[l*W +: W] != '0)
                |-> prod_o[l*W +: W] != '0); // R3

            AST_SQUARE_OF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                (hist_ok && a_d[l*W +: W] == ONE && b_d[l*W +: W] == ONE)
                |-> $countones(prod_o[l*W +: W]) == 1); // R1
        end
    endgenerate

endmodule

bind gf_tower_mul gf_tower_mul_chk #(
    .DEPTH  (DEPTH),
    .LANES  (LANES),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .prod_o(prod_o)
);

// File: tb/gf_tower_mul_tb_top.sv
`timescale 1ns/1ps
// Bench for gf_tower_mul: GF(2^8), two lanes, registered output.
// The reference model is a schoolbook (four-product) tower multiplication.
module gf_tower_mul_tb_top;

    localparam int         DEPTH = 3;
    localparam int         LANES = 2;
    localparam int         W     = 8;
    localparam logic [1:0] N4    = 2'b10;
    localparam logic [3:0] N8    = 4'b1100;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES*W-1:0]  opa = '0;
    logic [LANES*W-1:0]  opb = '0;
    logic [LANES*W-1:0]  prod;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    gf_tower_mul #(
        .DEPTH  (DEPTH),
        .LANES  (LANES),
        .REG_OUT(1'b1),
        .TOWER_N({N8, N4})
    ) dut_i (
        .clk   (clk),
        .rst_n (rst_n),
        .opa_i (opa),
        .opb_i (opb),
        .prod_o(prod)
    );

    // GF(4) over GF(2), a^2 = a + 1, schoolbook.
    function automatic logic [1:0] m2(input logic [1:0] x, input logic [1:0] y);
        logic p0, p1, p2;
        p0 = x[0] & y[0];
        p1 = (x[0] & y[1]) ^ (x[1] & y[0]);
        p2 = x[1] & y[1];
        return {p1 ^ p2, p0 ^ p2};
    endfunction

    // GF(16) over GF(4), a^2 = a + N4, schoolbook.
    function automatic logic [3:0] m4(input logic [3:0] x, input logic [3:0] y);
        logic [1:0] p0, p1, p2;
        p0 = m2(x[1:0], y[1:0]);
        p1 = m2(x[1:0], y[3:2]) ^ m2(x[3:2], y[1:0]);
        p2 = m2(x[3:2], y[3:2]);
        return {p1 ^ p2, p0 ^ m2(N4, p2)};
    endfunction

    // GF(256) over GF(16), a^2 = a + N8, schoolbook.
    function automatic logic [7:0] m8(input logic [7:0] x, input logic [7:0] y);
        logic [3:0] p0, p1, p2;
        p0 = m4(x[3:0], y[3:0]);
        p1 = m4(x[3:0], y[7:4]) ^ m4(x[7:4], y[3:0]);
        p2 = m4(x[7:4], y[7:4]);
        return {p1 ^ p2, p0 ^ m4(N8, p2)};
    endfunction

    task automatic check_eq(input string tag, input logic [LANES*W-1:0] act,
                            input logic [LANES*W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_nz(input string tag, input logic [W-1:0] act);
        n_cmp++;
        if (act == '0) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=nonzero", tag, act);
        end
    endtask

    // Drive one operand set at the falling edge, sample just after the rise.
    task automatic apply(input logic [W-1:0] a0, input logic [W-1:0] b0,
                         input logic [W-1:0] a1, input logic [W-1:0] b1);
        @(negedge clk);
        opa = {a1, a0};
        opb = {b1, b0};
        @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Main stimulus sequence.
    initial begin
        void'($urandom(32'h5EED_2006));

        // R9: reset clears the registered product even with live operands.
        opa = 16'hFFFF;
        opb = 16'h1357;
        repeat (3) @(posedge clk);
        #1;
        check_eq("R9 reset state", prod, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: generator squares of the top and middle levels.
        apply(8'h10, 8'h10, 8'h04, 8'h04);
        check_eq("R1 a*a top=1C mid=06", prod, {8'h06, 8'h1C});

        // R8: output holds until the next edge, then updates.
        @(negedge clk);
        opa = {8'h01, 8'h02};
        opb = {8'h5A, 8'h02};
        #1;
        check_eq("R8 hold before edge", prod, {8'h06, 8'h1C});
        @(posedge clk);
        #1;
        check_eq("R8 update after edge / R1 w*w=03", prod, {8'h5A, 8'h03});

        // Exhaustive: lane 0 (x,y), lane 1 (y,x).
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                logic [7:0] e;
                e = m8(8'(x), 8'(y));
                apply(8'(x), 8'(y), 8'(y), 8'(x));
                check_eq("R2 model", {8'h00, prod[7:0]}, {8'h00, e});
                check_eq("R4 commutative", {8'h00, prod[15:8]}, {8'h00, prod[7:0]});
                if (x == 0 || y == 0)
                    check_eq("R5 zero operand", {8'h00, prod[7:0]}, '0);
                else
                    check_nz("R3 no zero divisor", prod[7:0]);
                if (x == 1)
                    check_eq("R6 one identity", {8'h00, prod[7:0]}, {8'h00, 8'(y)});
            end
        end

        // R7: independent random pairs in each lane.
        for (int i = 0; i < 1000; i++) begin
            logic [7:0] a0, b0, a1, b1;
            a0 = 8'($urandom);
            b0 = 8'($urandom);
            a1 = 8'($urandom);
            b1 = 8'($urandom);
            apply(a0, b0, a1, b1);
            check_eq("R7 lanes independent", prod, {m8(a1, b1), m8(a0, b0)});
        end

        // R9: a mid-run reset clears again.
        @(negedge clk);
        opa = 16'hABCD;
        opb = 16'hEF01;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_eq("R9 mid-run reset", prod, '0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_eq("R7 after reset", prod, {m8(8'hAB, 8'hEF), m8(8'hCD, 8'h01)});

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule